// File: doc/BRIEF.md
# GPIO Controller with Edge Detection

This block is a register-mapped general-purpose I/O controller for `NGPIO` pins, where `NGPIO` is a multiple of 32 (64 by default, and 96 or 192 are also supported). Software reaches it through a simple 32-bit bus addressed in bytes. A write takes effect on the clock edge where the write enable is high. A read is combinational from the current register state.

Each pin has the following controls and results:
- a synchronised level readback;
- a direction bit;
- an output latch, changed only through separate write-one-to-set and write-one-to-clear banks;
- rising-edge and falling-edge enables;
- a sticky edge-status bit, cleared by writing a one;
- a two-bit alternate-function field, which is driven out of the block.

A single interrupt line is the OR of every status bit.

The register file holds nine word groups. The first seven groups are one-bit-per-pin banks of `NREG = NGPIO/32` words each. The alternate-function group that follows has `2*NREG` words. Pad muxing and the bus bridge sit outside the block.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Bank F (level=0, direction=1, set=2, clear=3, rise enable=4, fall enable=5, edge status=6) holds pin p in the word at byte offset F·NREG·4 + (p/32)·4, at bit p%32.
- R2: The level bank returns the synchronised pin state whatever the direction setting. A change on `pinIn` is visible there two clock edges later. Writes to the level bank have no effect.
- R3: A direction bit of 1 marks the pin as an output and 0 marks it as an input. The bits appear on `pinDir`, read back from bank 1, and change only when bank 1 is written.
- R4: Writing a word with 1 bits to the set bank drives those output latch bits high. Zero bits leave them unchanged. The latch appears on `pinOut`, and reads of both the set bank and the clear bank return it.
- R5: Writing a word with 1 bits to the clear bank drives those output latch bits low. Zero bits leave them unchanged.
- R6: With a pin's rise enable set, a 0→1 change on `pinIn` sets its status bit on the third clock edge after the change.
- R7: With a pin's fall enable set, a 1→0 change on `pinIn` sets its status bit on the third clock edge after the change.
- R8: A status bit stays set until a write of 1 to that bit of the status bank. Zero bits in the written word have no effect.
- R9: When a new edge reaches a status bit on the same edge as a write that clears it, the bit stays set.
- R10: `irq` is high exactly while at least one status bit is set.
- R11: Pin p's two-bit alternate-function field is in the word at byte offset 7·NREG·4 + (p/16)·4, at bits 2·(p%16)+1:2·(p%16). It appears on `altFunc[2p+1:2p]` and reads back from the same location.
- R12: After reset the direction, output latch, both enables, status and alternate-function registers are all zero, and `irq` is low.
- R13: Reads from offsets at or above 9·NREG·4, or from offsets that are not word-aligned, return 0. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte offset of the accessed word |
| busWrEn | input | 1 | Write strobe, taken on the rising clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` (combinational) |
| pinIn | input | NGPIO | Raw pin inputs |
| pinOut | output | NGPIO | Output latch |
| pinDir | output | NGPIO | Direction, 1 = output |
| altFunc | output | 2·NGPIO | Alternate-function fields, two bits per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
Results fall due on different cycles after their stimulus:
- Register writes show on the outputs and on readback right after the write edge.
- A pin change shows in the level bank after two edges.
- A pin change reaches the status bank and `irq` after three edges.

The bench changes pins and bus signals only at falling edges and samples half a cycle after a rising edge. The edge tests check status both one cycle early (still clear) and on time (set). The edge-versus-clear race is set up by timing the clearing write to commit on exactly the third edge after a pin change.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  typedef enum logic [2:0] {
    BK_LEVEL = 3'd0,
    BK_DIR   = 3'd1,
    BK_SET   = 3'd2,
    BK_CLR   = 3'd3,
    BK_RISE  = 3'd4,
    BK_FALL  = 3'd5,
    BK_STAT  = 3'd6,
    BK_ALT   = 3'd7
  } gpioBank_t;

  // Decoded access handed from control to datapath
  typedef struct packed {
    logic        hit;
    gpioBank_t   bank;
    logic [7:0]  word;
    logic        wrDir;
    logic        wrSet;
    logic        wrClr;
    logic        wrRise;
    logic        wrFall;
    logic        wrStat;
    logic        wrAlt;
    logic [31:0] data;
  } gpioStrobe_t;

endpackage

// File: rtl/gpio_edge_decode.sv
module gpio_edge_decode
  import gpio_edge_pkg::*;
#(
  parameter int NGPIO  = 64,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output gpioStrobe_t       strb
);

  localparam int NREG     = NGPIO / 32;
  localparam int BIT_WORDS = 7 * NREG;
  localparam int ALL_WORDS = 9 * NREG;

  int wordIdx;

  always_comb begin
    strb      = '0;
    strb.data = busWrData;
    wordIdx   = int'(busAddr[ADDR_W-1:2]);
    if (busAddr[1:0] == 2'b00) begin
      if (wordIdx < BIT_WORDS) begin
        strb.hit  = 1'b1;
        strb.bank = gpioBank_t'(3'(wordIdx / NREG));
        strb.word = 8'(wordIdx % NREG);
      end else if (wordIdx < ALL_WORDS) begin
        strb.hit  = 1'b1;
        strb.bank = BK_ALT;
        strb.word = 8'(wordIdx - BIT_WORDS);
      end
    end
    if (busWrEn && strb.hit) begin
      case (strb.bank)
        BK_DIR:  strb.wrDir  = 1'b1;
        BK_SET:  strb.wrSet  = 1'b1;
        BK_CLR:  strb.wrClr  = 1'b1;
        BK_RISE: strb.wrRise = 1'b1;
        BK_FALL: strb.wrFall = 1'b1;
        BK_STAT: strb.wrStat = 1'b1;
        BK_ALT:  strb.wrAlt  = 1'b1;
        default: ;
      endcase
    end
  end

  AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrDir, strb.wrSet, strb.wrClr, strb.wrRise,
              strb.wrFall, strb.wrStat, strb.wrAlt})); // R13

  AST_NO_WRITE_UNMAPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.hit) |-> ($countones({strb.wrDir, strb.wrSet, strb.wrClr, strb.wrRise,
                                  strb.wrFall, strb.wrStat, strb.wrAlt}) == 0)); // R13

endmodule

// File: rtl/gpio_edge_datapath.sv
module gpio_edge_datapath
  import gpio_edge_pkg::*;
#(
  parameter int NGPIO = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  gpioStrobe_t        strb,
  input  logic [NGPIO-1:0]   pinIn,
  output logic [31:0]        rdData,
  output logic [NGPIO-1:0]   pinOut,
  output logic [NGPIO-1:0]   pinDir,
  output logic [2*NGPIO-1:0] altFunc,
  output logic               irq
);

  localparam int NREG  = NGPIO / 32;
  localparam int NALTW = 2 * NREG;

  logic [NGPIO-1:0]   syncA, syncB, prevR;
  logic [NGPIO-1:0]   dirR, outR, riseR, fallR, statR;
  logic [2*NGPIO-1:0] altR;

  logic [NGPIO-1:0]   wordSel, fullData;
  logic [2*NGPIO-1:0] altSel, altData;
  logic [NGPIO-1:0]   setMask, clrMask, statClrMask, newEdge;

  // Per-word select masks
  for (genvar w = 0; w < NREG; w++) begin : g_bitWord
    assign wordSel[w*32 +: 32]  = {32{strb.word == 8'(w)}};
    assign fullData[w*32 +: 32] = strb.data;
  end
  for (genvar w = 0; w < NALTW; w++) begin : g_altWord
    assign altSel[w*32 +: 32]  = {32{strb.word == 8'(w)}};
    assign altData[w*32 +: 32] = strb.data;
  end

  assign setMask     = strb.wrSet  ? (fullData & wordSel) : '0;
  assign clrMask     = strb.wrClr  ? (fullData & wordSel) : '0;
  assign statClrMask = strb.wrStat ? (fullData & wordSel) : '0;
  assign newEdge     = (riseR & syncB & ~prevR) | (fallR & ~syncB & prevR);

  // Synchroniser and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevR <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevR <= syncB;
    end
  end

  // Control and status registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirR  <= '0;
      outR  <= '0;
      riseR <= '0;
      fallR <= '0;
      statR <= '0;
      altR  <= '0;
    end else begin
      if (strb.wrDir)  dirR  <= (dirR  & ~wordSel) | (fullData & wordSel);
      if (strb.wrRise) riseR <= (riseR & ~wordSel) | (fullData & wordSel);
      if (strb.wrFall) fallR <= (fallR & ~wordSel) | (fullData & wordSel);
      if (strb.wrAlt)  altR  <= (altR  & ~altSel)  | (altData  & altSel);
      outR  <= (outR | setMask) & ~clrMask;
      statR <= (statR & ~statClrMask) | newEdge;
    end
  end

  // Read mux
  int rdIdx;
  always_comb begin
    rdIdx  = int'(strb.word);
    rdData = '0;
    if (strb.hit) begin
      case (strb.bank)
        BK_LEVEL:       rdData = syncB[rdIdx*32 +: 32];
        BK_DIR:         rdData = dirR[rdIdx*32 +: 32];
        BK_SET, BK_CLR: rdData = outR[rdIdx*32 +: 32];
        BK_RISE:        rdData = riseR[rdIdx*32 +: 32];
        BK_FALL:        rdData = fallR[rdIdx*32 +: 32];
        BK_STAT:        rdData = statR[rdIdx*32 +: 32];
        BK_ALT:         rdData = altR[rdIdx*32 +: 32];
        default:        rdData = '0;
      endcase
    end
  end

  assign pinOut  = outR;
  assign pinDir  = dirR;
  assign altFunc = altR;
  assign irq     = |statR;

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDir |=> $stable(dirR)); // R3

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (|setMask) |=> ((outR & $past(setMask)) == $past(setMask))); // R4

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (|clrMask) |=> ((outR & $past(clrMask)) == '0)); // R5

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (|newEdge) |=> ((statR & $past(newEdge)) == $past(newEdge))); // R6 R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(statR) & ~statR & ~$past(statClrMask)) == '0)); // R8

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (|(newEdge & statClrMask)) |=>
      ((statR & $past(newEdge & statClrMask)) == $past(newEdge & statClrMask))); // R9

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NGPIO  = 64,
  parameter int ADDR_W = $clog2(NGPIO / 32 * 36)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  input  logic [NGPIO-1:0]   pinIn,
  output logic [NGPIO-1:0]   pinOut,
  output logic [NGPIO-1:0]   pinDir,
  output logic [2*NGPIO-1:0] altFunc,
  output logic               irq
);

  gpioStrobe_t strb;

  gpio_edge_decode #(.NGPIO(NGPIO), .ADDR_W(ADDR_W)) u_decode (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .strb      (strb)
  );

  gpio_edge_datapath #(.NGPIO(NGPIO)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .pinIn   (pinIn),
    .rdData  (busRdData),
    .pinOut  (pinOut),
    .pinDir  (pinDir),
    .altFunc (altFunc),
    .irq     (irq)
  );

  AST_IRQ_MEANS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> !$past(busWrEn && busAddr == ADDR_W'(0))); // R10

endmodule

// File: tb/tb_gpio_edge_ctrl.sv
module tb_gpio_edge_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NGPIO = 64;
  localparam int ADDR_W = 7;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [ADDR_W-1:0]  busAddr = '0;
  logic               busWrEn = 1'b0;
  logic [31:0]        busWrData = '0;
  logic [31:0]        busRdData;
  logic [NGPIO-1:0]   pinIn = '0;
  logic [NGPIO-1:0]   pinOut, pinDir;
  logic [2*NGPIO-1:0] altFunc;
  logic               irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_ctrl #(.NGPIO(NGPIO), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinDir(pinDir), .altFunc(altFunc), .irq(irq)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(int addr, logic [31:0] data);
    @(negedge clk);
    busAddr   = ADDR_W'(addr);
    busWrData = data;
    busWrEn   = 1'b1;
    @(negedge clk);
    busWrEn   = 1'b0;
  endtask

  task automatic busRead(int addr, output logic [31:0] data);
    busAddr = ADDR_W'(addr);
    #1;
    data = busRdData;
  endtask

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Byte offset for bank f, word w (NREG = 2)
  function automatic int offs(int f, int w);
    return (f * 2 + w) * 4;
  endfunction

  task automatic testReset();
    logic [31:0] d;
    check("R12 pinDir", pinDir, 64'h0);
    check("R12 pinOut", pinOut, 64'h0);
    check("R12 altFunc", altFunc[63:0] | altFunc[127:64], 64'h0);
    check("R12 irq", irq, 0);
    busRead(offs(4, 0), d); check("R12 rise enable", d, 0);
    busRead(offs(6, 1), d); check("R12 status", d, 0);
  endtask

  task automatic testLevel();
    logic [31:0] d;
    @(negedge clk);
    pinIn = 64'hDEAD_BEEF_1234_5678;
    @(negedge clk);
    busRead(offs(0, 0), d); check("R2 level not before 2 edges", d, 32'h0);
    @(negedge clk);
    busRead(offs(0, 0), d); check("R1 R2 level word0", d, 32'h1234_5678);
    busRead(offs(0, 1), d); check("R1 R2 level word1", d, 32'hDEAD_BEEF);
    busWrite(offs(0, 0), 32'h0);
    busRead(offs(0, 0), d); check("R2 level write ignored", d, 32'h1234_5678);
    busRead(offs(6, 0), d); check("R6 no status without enable", d, 0);
  endtask

  task automatic testDir();
    logic [31:0] d;
    busWrite(offs(1, 1), 32'hF0F0_0001);
    check("R3 pinDir", pinDir, 64'hF0F0_0001_0000_0000);
    busRead(offs(1, 1), d); check("R1 R3 dir readback", d, 32'hF0F0_0001);
    busRead(offs(0, 1), d); check("R2 level ignores direction", d, 32'hDEAD_BEEF);
  endtask

  task automatic testSetClr();
    logic [31:0] d;
    busWrite(offs(2, 0), 32'h0000_00FF);
    check("R4 set", pinOut, 64'h0000_0000_0000_00FF);
    busWrite(offs(2, 1), 32'h8000_0000);
    check("R4 set word1 keeps word0", pinOut, 64'h8000_0000_0000_00FF);
    busRead(offs(3, 0), d); check("R4 readback via clear bank", d, 32'h0000_00FF);
    busWrite(offs(3, 0), 32'h0000_000F);
    check("R5 clear", pinOut, 64'h8000_0000_0000_00F0);
    busWrite(offs(2, 0), 32'h0);
    check("R4 zero bits no effect", pinOut, 64'h8000_0000_0000_00F0);
  endtask

  task automatic testEdges();
    logic [31:0] d;
    @(negedge clk);
    pinIn = 64'h8000_0000_0000_0000;
    waitCycles(4);
    busWrite(offs(4, 0), 32'h0000_0001);
    busWrite(offs(5, 1), 32'h8000_0000);
    pinIn[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    busRead(offs(6, 0), d); check("R6 status not yet after 2 edges", d, 0);
    check("R10 irq still low", irq, 0);
    @(negedge clk);
    busRead(offs(6, 0), d); check("R6 rise sets status on 3rd edge", d, 32'h1);
    check("R10 irq high", irq, 1);
    pinIn[63] = 1'b0;
    waitCycles(3);
    busRead(offs(6, 1), d); check("R7 fall sets status", d, 32'h8000_0000);
    pinIn[0] = 1'b0;
    waitCycles(4);
    busRead(offs(6, 0), d); check("R7 fall without enable ignored", d, 32'h1);
  endtask

  task automatic testStatusClear();
    logic [31:0] d;
    busWrite(offs(6, 0), 32'h0);
    busRead(offs(6, 0), d); check("R8 write zero keeps status", d, 32'h1);
    busWrite(offs(6, 0), 32'h1);
    busRead(offs(6, 0), d); check("R8 write one clears", d, 32'h0);
    check("R10 irq held by other bit", irq, 1);
    busWrite(offs(6, 1), 32'h8000_0000);
    check("R10 irq low when all clear", irq, 0);
  endtask

  task automatic testRace();
    logic [31:0] d;
    pinIn[0] = 1'b1;
    waitCycles(4);
    busRead(offs(6, 0), d); check("R6 setup status", d, 32'h1);
    pinIn[0] = 1'b0;
    waitCycles(4);
    // rising edge lands on the same clock edge as the clearing write
    pinIn[0] = 1'b1;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    busAddr   = ADDR_W'(offs(6, 0));
    busWrData = 32'h1;
    busWrEn   = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    busRead(offs(6, 0), d); check("R9 edge wins over clear", d, 32'h1);
    busWrite(offs(6, 0), 32'h1);
    busRead(offs(6, 0), d); check("R9 later clear works", d, 32'h0);
  endtask

  task automatic testAlt();
    logic [31:0] d;
    busWrite(56, 32'h0000_000C);
    check("R11 pin1 field", altFunc[3:2], 2'd3);
    busWrite(68, 32'h8000_0000);
    check("R11 pin63 field", altFunc[127:126], 2'd2);
    busRead(56, d); check("R11 readback", d, 32'h0000_000C);
    check("R11 other fields zero", altFunc[125:4] | altFunc[1:0], 64'h0);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    busWrite(72, 32'hFFFF_FFFF);
    busWrite(offs(1, 0) + 1, 32'hFFFF_FFFF);
    check("R13 unmapped write no dir change", pinDir, 64'hF0F0_0001_0000_0000);
    busRead(72, d); check("R13 unmapped read zero", d, 0);
    busRead(offs(1, 1) + 2, d); check("R13 misaligned read zero", d, 0);
    busRead(offs(7, 3) + 4, d); check("R13 past alt bank zero", d, 0);
  endtask

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
    testReset();
    testLevel();
    testDir();
    testSetClr();
    testEdges();
    testStatusClear();
    testRace();
    testAlt();
    testUnmapped();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule